// File: doc/BRIEF.md
# Power-Up Strap Latch and Test-Mode Selector

This block samples a dual-purpose strap pin once, when power-good first rises after a power-on reset. The pin reaches the logic as two comparator results: one says the level is above 2.0 V and one says it is above the low frequency-select threshold. A high-level sample makes the pin a hardware test-mode request. Any lower level makes it the CPU frequency select: 0 is the default and picks a 133.33 MHz CPU clock, 1 picks 100 MHz. SRC stays at 100 MHz, REF at 14.318 MHz and DOT at 96 MHz in both cases.

Once the strap is latched, the block decides what overrides every clock output. In hardware test mode the override comes from the real-time test pin, after a synchroniser. If the strap did not request test mode, software can enter test mode through a register bit. In that case a second register bit alone chooses the override and the test pin has no effect. Test mode entered by either path lasts until the next power-on reset.

Top module: `strap_mode_ctl`

## Requirements
- R1: While reset is held, and after reset until power-good is first sampled high, `ovr_code` is 1 (Hi-Z), `test_active` is 0 and `fs_sel` is 0.
- R2: On the first clock edge that samples `pwr_good` high with `strap_hi` low, `fs_sel` takes the value of `strap_fs`. It is visible after that edge, and `test_active` stays 0.
- R3: If `strap_hi` is high on that edge, `test_active` becomes 1 after the edge and `fs_sel` is 0, whatever `strap_fs` is.
- R4: After the latch, `fs_sel` and the test-mode entry made by the strap do not change when `strap_hi`, `strap_fs` or `pwr_good` change.
- R5: In hardware test mode, `ovr_code` is 1 (Hi-Z) while the synchronised `tm_pin` is 0 and 2 (REF divided) while it is 1. A change on `tm_pin` reaches `ovr_code` SYNC_STAGES clock edges later.
- R6: In hardware test mode, `sw_test_en` and `sw_ovr_sel` have no effect on `ovr_code`.
- R7: After the latch, with no hardware test, an edge that samples `sw_test_en` high sets `test_active` to 1 after that edge.
- R8: In software test mode, `ovr_code` is 2 when `sw_ovr_sel` is 1 and 1 when it is 0, with no added delay. `tm_pin` has no effect.
- R9: Once `test_active` is 1 it stays 1 until reset, even if `sw_test_en` is cleared.
- R10: After the latch with no test mode, `ovr_code` is 0 (normal). The value 3 never appears.
- R11: `sw_test_en` sampled high before the latch does not enter test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| pwr_good | input | 1 | Power-good; its first high sample latches the strap |
| strap_hi | input | 1 | Strap comparator: level above 2.0 V |
| strap_fs | input | 1 | Strap comparator: level above the frequency-select threshold |
| tm_pin | input | 1 | Asynchronous real-time test-mode pin |
| sw_test_en | input | 1 | Register bit: software test-mode entry |
| sw_ovr_sel | input | 1 | Register bit: software override select, 1 = REF divided |
| fs_sel | output | 1 | Latched frequency select, 0 = 133.33 MHz CPU, 1 = 100 MHz |
| test_active | output | 1 | Test mode entered by either path |
| ovr_code | output | 2 | 0 normal, 1 Hi-Z, 2 REF divided |

## Verification
The bench builds the block with SYNC_STAGES = 2, the default. With that value the two-edge delay of the test pin is short enough to check edge by edge right after each toggle. It also lets random toggling of `tm_pin` hit cycles where the pin moves while the previous change is still inside the synchroniser. The bench applies several power cycles with random strap levels. These reach both the hardware and the software test path, and they exercise strap and power-good changes after the latch.

// File: rtl/strap_mode_ctl.sv
module strap_mode_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       strap_hi,
  input  logic       strap_fs,
  input  logic       tm_pin,
  input  logic       sw_test_en,
  input  logic       sw_ovr_sel,
  output logic       fs_sel,
  output logic       test_active,
  output logic [1:0] ovr_code
);
  localparam logic [1:0] OVR_NORMAL = 2'd0;
  localparam logic [1:0] OVR_HIZ    = 2'd1;
  localparam logic [1:0] OVR_REFDIV = 2'd2;
  localparam int         SYNC_LAST  = SYNC_STAGES - 1;

  logic                   latched, hw_test, sw_test, fs_q;
  logic [SYNC_STAGES-1:0] tm_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tm_sync <= '0;
    else        tm_sync <= {tm_sync[SYNC_STAGES-2:0], tm_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      hw_test <= 1'b0;
      sw_test <= 1'b0;
      fs_q    <= 1'b0;
    end else if (!latched) begin
      if (pwr_good) begin
        latched <= 1'b1;
        hw_test <= strap_hi;
        fs_q    <= strap_hi ? 1'b0 : strap_fs;
      end
    end else if (!hw_test && sw_test_en) begin
      sw_test <= 1'b1;
    end
  end

  assign fs_sel      = fs_q;
  assign test_active = hw_test | sw_test;

  always_comb begin
    if (!latched)     ovr_code = OVR_HIZ;
    else if (hw_test) ovr_code = tm_sync[SYNC_LAST] ? OVR_REFDIV : OVR_HIZ;
    else if (sw_test) ovr_code = sw_ovr_sel ? OVR_REFDIV : OVR_HIZ;
    else              ovr_code = OVR_NORMAL;
  end

  p_prelatch_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> (ovr_code == OVR_HIZ && !test_active && !fs_sel));
  p_fs_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(fs_sel));
  p_test_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |=> test_active);
  p_strap_test_fs_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_test |-> !fs_sel);
  p_paths_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_test && sw_test));
  p_normal_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !test_active) |-> ovr_code == OVR_NORMAL);
  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_code != 2'd3);
endmodule

// File: tb/strap_mode_ctl_tb.sv
module strap_mode_ctl_tb;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 0, strap_hi = 0, strap_fs = 0, tm_pin = 0, sw_test_en = 0, sw_ovr_sel = 0;
  logic fs_sel, test_active;
  logic [1:0] ovr_code;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic finished = 0;

  logic m_lat, m_hw, m_sw, m_fs;
  logic [SYNC-1:0] m_tm;

  strap_mode_ctl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_hi(strap_hi),
    .strap_fs(strap_fs), .tm_pin(tm_pin), .sw_test_en(sw_test_en),
    .sw_ovr_sel(sw_ovr_sel), .fs_sel(fs_sel), .test_active(test_active),
    .ovr_code(ovr_code));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] exp_ovr();
    if (!m_lat) return 2'd1;
    if (m_hw)   return m_tm[SYNC-1] ? 2'd2 : 2'd1;
    if (m_sw)   return sw_ovr_sel ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  function automatic logic exp_test();
    return m_hw | m_sw;
  endfunction

  task automatic model_reset();
    m_lat = 0; m_hw = 0; m_sw = 0; m_fs = 0; m_tm = '0;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (fs_sel !== m_fs || test_active !== exp_test() || ovr_code !== exp_ovr()) begin
      n_bad++;
      $display("FAIL %s: fs_sel=%0b test_active=%0b ovr_code=%0d expected %0b %0b %0d",
               tag, fs_sel, test_active, ovr_code, m_fs, exp_test(), exp_ovr());
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (!m_lat) begin
      if (pwr_good) begin m_lat = 1; m_hw = strap_hi; m_fs = strap_hi ? 1'b0 : strap_fs; end
    end else if (!m_hw && sw_test_en) m_sw = 1;
    m_tm = {m_tm[SYNC-2:0], tm_pin};
    @(negedge clk);
    check(tag);
  endtask

  task automatic power_cycle();
    rst_n = 0; pwr_good = 0; sw_test_en = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1;
  endtask

  initial begin
    while (cyc < 150000 && !finished) @(negedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    @(negedge clk);
    power_cycle();
    // R1 / R11: no latch yet, register entry ignored
    sw_test_en = 1; strap_fs = 1;
    repeat (3) step("R11");
    sw_test_en = 0;
    // R2: frequency-select strap
    pwr_good = 1; step("R2");
    step("R10");
    // R4: later strap and power-good changes ignored
    strap_fs = 0; strap_hi = 1; pwr_good = 0; step("R4");
    pwr_good = 1; step("R4");
    strap_hi = 0;
    // R7 / R8: software entry and select, test pin ignored
    sw_test_en = 1; sw_ovr_sel = 0; step("R7");
    tm_pin = 1; step("R8"); step("R8");
    sw_ovr_sel = 1; step("R8");
    sw_test_en = 0; tm_pin = 0; step("R9"); step("R9");

    // hardware test path
    power_cycle();
    strap_hi = 1; strap_fs = 1; pwr_good = 1; tm_pin = 0;
    step("R3");
    tm_pin = 1; step("R5"); step("R5"); step("R5");
    tm_pin = 0; step("R5"); step("R5");
    sw_test_en = 1; sw_ovr_sel = 1; step("R6"); step("R6");
    strap_hi = 0; pwr_good = 0; step("R4");

    // random power cycles
    for (int pc = 0; pc < 40; pc++) begin
      power_cycle();
      strap_hi = $urandom_range(0, 3) == 0; strap_fs = $urandom_range(0, 1);
      for (int k = 0; k < 60; k++) begin
        pwr_good   = (k > 2) ? ($urandom_range(0, 7) != 0) : 1'b0;
        strap_hi   = $urandom_range(0, 1) ? strap_hi : ~strap_hi;
        strap_fs   = $urandom_range(0, 1);
        tm_pin     = $urandom_range(0, 1);
        sw_test_en = $urandom_range(0, 9) == 0;
        sw_ovr_sel = $urandom_range(0, 1);
        step(m_hw ? "R5" : (m_sw ? "R8" : (m_lat ? "R10" : "R1")));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule